// File: doc/BRIEF.md
# T1 Serial Transmit Port

This block turns parallel channel octets into a T1 line bit stream. One frame is 193 bit periods long. It begins with a single framing bit and then carries 24 channel slots of 8 bits each. An external sync input sets the frame position. After the first sync is recognised, the port asks for the octet of each slot one slot period ahead of that slot. It loads the octet at the slot boundary and shifts it out MSB first. At each frame start it inserts the framing bit taken from a supplied input.

The serial output and the sync input each use their own clock edge, chosen by a static select pin. Any of the four combinations is legal. The internal counters run on the rising edge. The falling-edge choices add one negative-edge register on the sync input path and one on the data output path. A sync pulse that arrives away from the expected frame boundary realigns the frame and raises a one-cycle flag.

Top module: `t1_tx_port`

## Requirements
- R1: After reset and until the first sync is recognised, `tdat_o` is 1 and `oct_req_o` stays low.
- R2: Once aligned, a frame is 193 bit periods: bit 0 is the framing bit, and bits 1..192 carry slots 0..23, 8 bits each, in rising slot order.
- R3: The framing bit sent is the value of `fbit_i` sampled on the rising edge that starts the framing period.
- R4: `oct_req_o` pulses for one cycle with `oct_slot_o` = s while bit 8s−7 of the frame is on the line (bit 186 for slot 0), so each request comes one slot ahead of its slot.
- R5: An octet is sent MSB first. An octet accepted with `oct_valid_i` during a slot is held and sent in the next slot.
- R6: A slot for which no octet was accepted is sent as all ones. A held octet is used only once.
- R7: If `oct_valid_i` is high in the cycle whose closing edge starts a slot, that octet goes into that slot.
- R8: With `sync_fall_i`=0, sync is sampled on the rising clock edge. With `sync_fall_i`=1, it is sampled on the falling edge. The framing bit leaves on the rising edge after the sample that first finds sync high.
- R9: With `data_fall_i`=0, `tdat_o` changes on the rising edge. With `data_fall_i`=1, it changes on the next falling edge.
- R10: Only the first sample of a sync pulse counts. Sync held high for several cycles aligns the frame once.
- R11: A sync recognised while aligned, anywhere other than the last bit of the frame, restarts the frame at the framing bit and raises `misalign_o` for that one bit period. The first sync and a sync on the expected boundary raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_fall_i | input | 1 | Sync sample edge: 0 rising, 1 falling |
| data_fall_i | input | 1 | Data launch edge: 0 rising, 1 falling |
| sync_i | input | 1 | Frame sync pulse |
| fbit_i | input | 1 | Framing bit value for the next frame |
| oct_valid_i | input | 1 | Octet on `oct_data_i` is valid |
| oct_data_i | input | 8 | Channel octet |
| oct_req_o | output | 1 | Octet request pulse |
| oct_slot_o | output | 5 | Slot index of the request |
| tdat_o | output | 1 | Serial T1 data |
| misalign_o | output | 1 | Sync arrived off the frame boundary |

## Verification
An octet can be delivered in the same cycle whose closing edge loads that octet's slot into the shifter. The bench places a write exactly in the last bit period of the slot before. It expects that octet to appear in the very next slot, MSB first, and the slot after it to go out as all ones. A held write made earlier in a slot is then checked to land one slot later. This separates the bypass path from the held path.

// File: rtl/t1_tx_pkg.sv
package t1_tx_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;

  function automatic int frame_len(input int slots, input int bits);
    return slots * bits + 1;
  endfunction
endpackage

// File: rtl/t1_edge_sampler.sv
module t1_edge_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  input  logic sync_i,
  output logic hit_o
);
  import t1_tx_pkg::*;

  logic neg_q, prev_q, samp;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= 1'b0;
    else         neg_q <= sync_i;
  end

  // rising mode: the posedge consumers sample sync_i directly
  assign samp = (edge_sel_e'(fall_i) == EDGE_FALL) ? neg_q : sync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= samp;
  end

  assign hit_o = samp & ~prev_q;
endmodule

// File: rtl/t1_frame_ctr.sv
module t1_frame_ctr #(
  parameter int SLOTS = 24,
  parameter int BITS  = 8,
  localparam int FRAME_LEN = t1_tx_pkg::frame_len(SLOTS, BITS),
  localparam int POS_W  = $clog2(FRAME_LEN),
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  output logic [POS_W-1:0]  pos_o,
  output logic              locked_o,
  output logic              run_nxt_o,
  output logic              fstb_o,
  output logic              load_o,
  output logic              req_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              misal_o
);
  typedef logic [POS_W-1:0] pos_t;
  localparam pos_t LAST     = pos_t'(FRAME_LEN - 1);
  localparam pos_t REQ0     = pos_t'(FRAME_LEN - BITS + 1);
  localparam pos_t REQ_LAST = pos_t'(1 + BITS * (SLOTS - 2));
  localparam pos_t BITS_P   = pos_t'(BITS);
  localparam pos_t ONE      = pos_t'(1);

  pos_t pos_q, pos_nxt, off_nxt, off_cur;
  logic locked_q, misal_q;

  always_comb begin
    run_nxt_o = locked_q | hit_i;
    if (hit_i || !locked_q)  pos_nxt = '0;
    else if (pos_q == LAST)  pos_nxt = '0;
    else                     pos_nxt = pos_q + ONE;
    off_nxt = pos_nxt - ONE;
    fstb_o  = run_nxt_o && (pos_nxt == '0);
    load_o  = run_nxt_o && !hit_i && (pos_nxt != '0) && ((off_nxt % BITS_P) == '0);
  end

  always_comb begin
    off_cur = pos_q - ONE;
    req_o   = 1'b0;
    slot_o  = '0;
    if (locked_q) begin
      if (pos_q == REQ0) begin
        req_o = 1'b1;
      end else if ((pos_q != '0) && (pos_q <= REQ_LAST) && ((off_cur % BITS_P) == '0)) begin
        req_o  = 1'b1;
        slot_o = SLOT_W'(off_cur / BITS_P) + SLOT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '0;
      locked_q <= 1'b0;
      misal_q  <= 1'b0;
    end else begin
      pos_q    <= pos_nxt;
      locked_q <= run_nxt_o;
      misal_q  <= hit_i && locked_q && (pos_q != LAST);
    end
  end

  assign pos_o    = pos_q;
  assign locked_o = locked_q;
  assign misal_o  = misal_q;
endmodule

// File: rtl/t1_octet_shifter.sv
module t1_octet_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            fstb_i,
  input  logic            load_i,
  input  logic            fbit_i,
  input  logic            oct_valid_i,
  input  logic [BITS-1:0] oct_data_i,
  output logic            bit_o
);
  logic [BITS-1:0] hold_q, sh_q, load_val;
  logic            hold_v_q, bit_q;

  // same-edge octet bypasses the holding register
  always_comb begin
    if (oct_valid_i)   load_val = oct_data_i;
    else if (hold_v_q) load_val = hold_q;
    else               load_val = '1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= '1;
      hold_v_q <= 1'b0;
    end else if (load_i) begin
      hold_v_q <= 1'b0;
    end else if (oct_valid_i) begin
      hold_q   <= oct_data_i;
      hold_v_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= 1'b1;
      sh_q  <= '1;
    end else if (!run_i) begin
      bit_q <= 1'b1;
      sh_q  <= '1;
    end else if (fstb_i) begin
      bit_q <= fbit_i;
      sh_q  <= '1;
    end else if (load_i) begin
      bit_q <= load_val[BITS-1];
      sh_q  <= {load_val[BITS-2:0], 1'b1};
    end else begin
      bit_q <= sh_q[BITS-1];
      sh_q  <= {sh_q[BITS-2:0], 1'b1};
    end
  end

  assign bit_o = bit_q;
endmodule

// File: rtl/t1_out_launch.sv
module t1_out_launch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  input  logic d_i,
  output logic q_o
);
  import t1_tx_pkg::*;

  logic neg_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= 1'b1;
    else         neg_q <= d_i;
  end

  assign q_o = (edge_sel_e'(fall_i) == EDGE_FALL) ? neg_q : d_i;
endmodule

// File: rtl/t1_tx_port.sv
module t1_tx_port #(
  parameter int SLOTS = 24,
  parameter int BITS  = 8,
  localparam int FRAME_LEN = t1_tx_pkg::frame_len(SLOTS, BITS),
  localparam int POS_W  = $clog2(FRAME_LEN),
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_fall_i,
  input  logic              data_fall_i,
  input  logic              sync_i,
  input  logic              fbit_i,
  input  logic              oct_valid_i,
  input  logic [BITS-1:0]   oct_data_i,
  output logic              oct_req_o,
  output logic [SLOT_W-1:0] oct_slot_o,
  output logic              tdat_o,
  output logic              misalign_o
);
  logic             hit, locked, run_nxt, fstb, load, tx_bit;
  logic [POS_W-1:0] pos;

  t1_edge_sampler i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fall_i (sync_fall_i),
    .sync_i (sync_i),
    .hit_o  (hit)
  );

  t1_frame_ctr #(.SLOTS(SLOTS), .BITS(BITS)) i_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit),
    .pos_o     (pos),
    .locked_o  (locked),
    .run_nxt_o (run_nxt),
    .fstb_o    (fstb),
    .load_o    (load),
    .req_o     (oct_req_o),
    .slot_o    (oct_slot_o),
    .misal_o   (misalign_o)
  );

  t1_octet_shifter #(.BITS(BITS)) i_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_nxt),
    .fstb_i      (fstb),
    .load_i      (load),
    .fbit_i      (fbit_i),
    .oct_valid_i (oct_valid_i),
    .oct_data_i  (oct_data_i),
    .bit_o       (tx_bit)
  );

  t1_out_launch i_launch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fall_i (data_fall_i),
    .d_i    (tx_bit),
    .q_o    (tdat_o)
  );
endmodule

// File: rtl/t1_tx_port_chk.sv
module t1_tx_port_chk #(
  parameter int SLOTS = 24,
  parameter int BITS  = 8,
  localparam int FRAME_LEN = t1_tx_pkg::frame_len(SLOTS, BITS),
  localparam int POS_W  = $clog2(FRAME_LEN),
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              oct_req_o,
  input logic [SLOT_W-1:0] oct_slot_o,
  input logic              misalign_o,
  input logic [POS_W-1:0]  pos_i,
  input logic              locked_i,
  input logic              bit_i
);
  localparam logic [POS_W-1:0]  LAST    = POS_W'(FRAME_LEN - 1);
  localparam logic [SLOT_W:0]   NSLOT   = (SLOT_W + 1)'(SLOTS);

  assert_idle_until_sync_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_i |-> (bit_i && !oct_req_o));

  assert_pos_advance_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_i && pos_i != LAST) |=> (pos_i == $past(pos_i) + POS_W'(1)) || (pos_i == '0));

  assert_req_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oct_req_o |=> !oct_req_o);

  assert_req_slot_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oct_req_o |-> ({1'b0, oct_slot_o} < NSLOT));

  assert_misal_at_fbit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (locked_i && pos_i == '0));

  assert_misal_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |=> !misalign_o);
endmodule

bind t1_tx_port t1_tx_port_chk #(.SLOTS(SLOTS), .BITS(BITS)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .oct_req_o  (oct_req_o),
  .oct_slot_o (oct_slot_o),
  .misalign_o (misalign_o),
  .pos_i      (pos),
  .locked_i   (locked),
  .bit_i      (tx_bit)
);

// File: tb/test_t1_tx_port.sv
module test_t1_tx_port;
  localparam int FLEN = 193;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sync = 1'b0, sync_fall = 1'b0, data_fall = 1'b0, fbit = 1'b1;
  logic oct_valid = 1'b0;
  logic [7:0] oct_data = '0;
  logic req, tdat, misal;
  logic [4:0] slot;

  int n_tests = 0, n_fail = 0;
  logic nxt_sync = 1'b0, nxt_fbit = 1'b1, pend = 1'b0, resp_en = 1'b1;
  logic [7:0] pend_d = '0, seed = '0;

  // {sync_fall, data_fall, first fbit, data seed}
  localparam logic [10:0] VEC [4] = '{
    {1'b0, 1'b0, 1'b1, 8'h3C},
    {1'b0, 1'b1, 1'b0, 8'hC3},
    {1'b1, 1'b0, 1'b1, 8'h5A},
    {1'b1, 1'b1, 1'b0, 8'h96}
  };

  always #4 clk = ~clk;

  t1_tx_port i_t1_tx_port (
    .clk_i (clk), .rst_ni (rst_n), .sync_fall_i (sync_fall), .data_fall_i (data_fall),
    .sync_i (sync), .fbit_i (fbit), .oct_valid_i (oct_valid), .oct_data_i (oct_data),
    .oct_req_o (req), .oct_slot_o (slot), .tdat_o (tdat), .misalign_o (misal)
  );

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #(8 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  function automatic logic [7:0] dfun(input int s);
    return seed ^ 8'(s * 29);
  endfunction

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  // one bit period: drive at +1, sample at +6
  task automatic cyc();
    @(posedge clk); #1;
    sync = nxt_sync; fbit = nxt_fbit;
    oct_valid = pend; oct_data = pend_d; pend = 1'b0;
    #5;
    if (req && resp_en) begin pend = 1'b1; pend_d = dfun(int'(slot)); end
  endtask

  task automatic do_reset(input logic se, input logic de);
    rst_n = 1'b0; nxt_sync = 1'b0; sync = 1'b0; pend = 1'b0; oct_valid = 1'b0;
    sync_fall = se; data_fall = de;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    #5;
  endtask

  task automatic lock();
    nxt_sync = 1'b1; cyc(); nxt_sync = 1'b0; cyc();
  endtask

  initial begin
    // vector table: every edge combination, two frames each
    for (int v = 0; v < 4; v++) begin
      int e_idle, e_bit, e_f, e_req, e_mis;
      logic f0;
      f0 = VEC[v][8]; seed = VEC[v][7:0]; resp_en = 1'b1;
      do_reset(VEC[v][10], VEC[v][9]);
      e_idle = 0;
      for (int i = 0; i < 10; i++) begin
        cyc();
        if (tdat !== 1'b1 || req !== 1'b0) e_idle++;
      end
      chk(e_idle == 0, "R1 idle before sync", e_idle, 0);
      nxt_fbit = f0;
      lock();
      e_bit = 0; e_f = 0; e_req = 0; e_mis = 0;
      for (int fr = 0; fr < 2; fr++) begin
        for (int p = 0; p < FLEN; p++) begin
          logic eb, er;
          int es;
          if (!(fr == 0 && p == 0)) cyc();
          if (p == 0) begin
            eb = (fr == 0) ? f0 : ~f0;
            if (tdat !== eb) e_f++;
            if (fr == 0) nxt_fbit = ~f0;
          end else begin
            int s, k;
            s = (p - 1) / 8; k = (p - 1) % 8;
            eb = (fr == 0 && s == 0) ? 1'b1 : dfun(s)[7-k];
            if (tdat !== eb) e_bit++;
          end
          er = (p == 186) || (p >= 1 && p <= 177 && (p - 1) % 8 == 0);
          es = (p == 186) ? 0 : (p - 1) / 8 + 1;
          if (req !== er || (er && int'(slot) != es)) e_req++;
          if (misal !== 1'b0) e_mis++;
        end
      end
      chk(e_bit == 0, "R2/R5/R6 slot bits", e_bit, 0);
      chk(e_f == 0, "R3 framing bit", e_f, 0);
      chk(e_req == 0, "R4 request timing", e_req, 0);
      chk(e_mis == 0, "R11 no flag when aligned", e_mis, 0);
    end

    // R9: launch edge of the framing bit
    for (int de = 0; de < 2; de++) begin
      do_reset(1'b0, 1'(de));
      nxt_fbit = 1'b0;
      nxt_sync = 1'b1; cyc(); nxt_sync = 1'b0;
      @(posedge clk); #1;
      sync = 1'b0; fbit = 1'b0;
      chk(tdat === ((de == 1) ? 1'b1 : 1'b0), "R9 before falling edge", int'(tdat), de);
      #5;
      chk(tdat === 1'b0, "R9 after falling edge", int'(tdat), 0);
    end

    // R8: pulse only visible at one edge type
    for (int se = 0; se < 2; se++) begin
      do_reset(1'(se), 1'b0);
      nxt_fbit = 1'b0; fbit = 1'b0;
      @(posedge clk); #5 sync = 1'b1;
      @(posedge clk); #1 sync = 1'b0;
      #5;
      chk(tdat === ((se == 1) ? 1'b1 : 1'b0), "R8 late pulse", int'(tdat), se);
      do_reset(1'(se), 1'b0);
      fbit = 1'b0;
      @(posedge clk); #1 sync = 1'b1;
      #4 sync = 1'b0;
      @(posedge clk); #1; #5;
      chk(tdat === ((se == 1) ? 1'b0 : 1'b1), "R8 early pulse", int'(tdat), 1 - se);
    end

    // R7 bypass on the load edge, R5 held octet, R6 empty slot
    begin
      logic [7:0] got1, got2, got3;
      do_reset(1'b0, 1'b0);
      resp_en = 1'b0; nxt_fbit = 1'b0;
      lock();
      repeat (7) cyc();
      pend = 1'b1; pend_d = 8'hA5;
      cyc();
      chk(tdat === 1'b1, "R6 slot0 idle tail", int'(tdat), 1);
      for (int i = 0; i < 8; i++) begin cyc(); got1 = {got1[6:0], tdat}; end
      chk(got1 == 8'hA5, "R7 same-edge octet", int'(got1), 8'hA5);
      for (int i = 0; i < 8; i++) begin
        cyc(); got2 = {got2[6:0], tdat};
        if (i == 2) begin pend = 1'b1; pend_d = 8'h3C; end
      end
      chk(got2 == 8'hFF, "R6 unfilled slot", int'(got2), 8'hFF);
      for (int i = 0; i < 8; i++) begin cyc(); got3 = {got3[6:0], tdat}; end
      chk(got3 == 8'h3C, "R5 held octet MSB first", int'(got3), 8'h3C);
    end

    // R11 realign mid-frame, R10 held sync on the boundary
    begin
      int e_one, e_mis;
      repeat (18) cyc();
      nxt_sync = 1'b1; cyc(); nxt_sync = 1'b0; cyc();
      chk(tdat === 1'b0 && misal === 1'b1, "R11 realign flag", int'(misal), 1);
      cyc();
      chk(misal === 1'b0, "R11 flag one cycle", int'(misal), 0);
      repeat (190) cyc();
      nxt_sync = 1'b1; cyc(); cyc();
      chk(tdat === 1'b0 && misal === 1'b0, "R11 boundary sync no flag", int'(misal), 0);
      cyc(); cyc();
      nxt_sync = 1'b0;
      e_one = 0; e_mis = 0;
      for (int i = 0; i < 190; i++) begin
        cyc();
        if (tdat !== 1'b1) e_one++;
        if (misal !== 1'b0) e_mis++;
      end
      chk(e_one == 0 && e_mis == 0, "R10 held sync counts once", e_one + e_mis, 0);
      cyc();
      chk(tdat === 1'b0, "R10 next framing bit", int'(tdat), 0);
    end

    summary();
    $finish;
  end
endmodule